// File: doc/BRIEF.md
# Scanned Four-Digit State Display

This block drives four time-multiplexed seven-segment digits so that an 11-bit one-hot state vector can be read at a glance. Three digits show the raw vector as hexadecimal. The remaining digit shows the position of the single set bit, worked out by a one-hot-to-binary encoder. The cathode bus is shared by all four digits. A 2-bit scan select picks which digit drives the bus, and the same select enables that digit's anode, so data and anode always move together.

The scan select is taken from two neighbouring bits of an external free-running divider. Cathodes and anodes are both active-low. While the vector reports the opening state, the whole display blinks: every segment is forced dark during the high half of each period of the slow system clock. Both outputs are registered on the fast clock, so each result appears one clock after its inputs are sampled.

Top module: `state_display_scan`

## Requirements
- R1: While `rst` is high at a clock edge, the following cycle shows all four anodes high and all seven cathodes high (display dark).
- R2: Outside reset, one clock after `scan_sel` = k is sampled, `an_n[k]` is low and the other three anodes are high. Exactly one anode is low in every cycle after reset.
- R3: The digit shown for k=1 is `state_vec[3:0]`, for k=2 it is `state_vec[7:4]`, and for k=3 it is `{1'b0, state_vec[10:8]}`.
- R4: The digit shown for k=0 is the index i of the single set bit when `state_vec` is one-hot (i = 0 to 10, shown as hex 0 to A).
- R5: When `state_vec` is all zero or has more than one bit set, the k=0 digit shows F.
- R6: Cathode bit 0 is segment a, and bits 1 to 6 are segments b to g in order; a low bit lights its segment. The lit sets are: 0=abcdef, 1=bc, 2=abdeg, 3=abcdg, 4=bcfg, 5=acdfg, 6=acdefg, 7=abc, 8=all, 9=abcdfg (bottom segment lit), A=abcefg, b=cdefg, C=adef, d=bcdeg, E=adefg, F=aefg.
- R7: When `state_vec[9]` (opening) and `slow_clk` are both high at a sample, all seven cathodes are high one clock later, whatever digit is selected.
- R8: When `state_vec[9]` is low, or `slow_clk` is low, the decoded digit is shown unblanked, whatever the level of `slow_clk` or the other state bits.
- R9: Anodes and cathodes are updated on the same clock edge from the same sampled select, so a select that changes every cycle never pairs one digit's anode with another digit's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast display clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_sel | input | 2 | Digit scan select from the divider |
| slow_clk | input | 1 | Slow system clock used as the blink phase |
| state_vec | input | 11 | One-hot state vector to display |
| an_n | output | 4 | Active-low digit anodes |
| seg_n | output | 7 | Active-low cathodes, bit 0 = a to bit 6 = g |

## Verification
Every result of this block is due exactly one fast clock after the inputs that cause it: anode choice, decoded digit, index digit and blanking all leave through the same output registers. The bench drives a new select, blink phase and state vector on each falling edge. On the next falling edge it compares both output buses against a model evaluated on the inputs it applied one cycle earlier. This one-cycle offset is used for every vector, including reset entry and the cycle-by-cycle select changes, so a result that is late or early by a single cycle counts as a miscompare.

// File: rtl/disp_pkg.sv
package disp_pkg;
  localparam int NIB_W   = 4;
  localparam int SEG_W   = 7;
  localparam int N_DIGIT = 4;
  localparam int SEL_W   = $clog2(N_DIGIT);
  localparam logic [NIB_W-1:0] BAD_INDEX = 4'hF;
endpackage

// File: rtl/onehot_index.sv
module onehot_index
  import disp_pkg::*;
#(
  parameter int IN_W = 11
) (
  input  logic [IN_W-1:0]  vec,
  output logic [NIB_W-1:0] idx
);
  localparam int CNT_W = $clog2(IN_W + 1);

  logic [CNT_W-1:0] ones;
  logic [NIB_W-1:0] pos;

  always_comb begin
    ones = '0;
    pos  = '0;
    for (int i = 0; i < IN_W; i++) begin
      if (vec[i]) begin
        ones = ones + 1'b1;
        pos  = NIB_W'(i);
      end
    end
    idx = (ones == CNT_W'(1)) ? pos : BAD_INDEX;
  end
endmodule

// File: rtl/digit_select.sv
module digit_select
  import disp_pkg::*;
#(
  parameter int STATE_W = 11
) (
  input  logic [STATE_W-1:0] vec,
  input  logic [NIB_W-1:0]   idx,
  input  logic [SEL_W-1:0]   sel,
  output logic [NIB_W-1:0]   digit
);
  localparam int RAW_DIG = N_DIGIT - 1;
  localparam int PAD_W   = RAW_DIG * NIB_W;

  logic [PAD_W-1:0] padded;
  logic [NIB_W-1:0] nib [N_DIGIT];

  assign padded = {{(PAD_W - STATE_W){1'b0}}, vec};
  assign nib[0] = idx;

  for (genvar k = 1; k < N_DIGIT; k++) begin : g_raw
    assign nib[k] = padded[k*NIB_W-1 -: NIB_W];
  end

  assign digit = nib[sel];
endmodule

// File: rtl/anode_decode.sv
module anode_decode
  import disp_pkg::*;
(
  input  logic [SEL_W-1:0]   sel,
  output logic [N_DIGIT-1:0] an_n
);
  always_comb begin
    an_n = '1;
    an_n[sel] = 1'b0;
  end
endmodule

// File: rtl/seg_decode.sv
module seg_decode
  import disp_pkg::*;
(
  input  logic [NIB_W-1:0] hex,
  output logic [SEG_W-1:0] seg_n
);
  logic [SEG_W-1:0] lit;

  always_comb begin
    unique case (hex)
      4'h0: lit = 7'b0111111;
      4'h1: lit = 7'b0000110;
      4'h2: lit = 7'b1011011;
      4'h3: lit = 7'b1001111;
      4'h4: lit = 7'b1100110;
      4'h5: lit = 7'b1101101;
      4'h6: lit = 7'b1111101;
      4'h7: lit = 7'b0000111;
      4'h8: lit = 7'b1111111;
      4'h9: lit = 7'b1101111;
      4'hA: lit = 7'b1110111;
      4'hB: lit = 7'b1111100;
      4'hC: lit = 7'b0111001;
      4'hD: lit = 7'b1011110;
      4'hE: lit = 7'b1111001;
      default: lit = 7'b1110001;
    endcase
    seg_n = ~lit;
  end
endmodule

// File: rtl/state_display_scan.sv
module state_display_scan
  import disp_pkg::*;
#(
  parameter int STATE_W  = 11,
  parameter int OPEN_BIT = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         scan_sel,
  input  logic               slow_clk,
  input  logic [STATE_W-1:0] state_vec,
  output logic [3:0]         an_n,
  output logic [6:0]         seg_n
);
  logic [NIB_W-1:0]   index_d;
  logic [NIB_W-1:0]   digit_d;
  logic [SEG_W-1:0]   seg_d;
  logic [N_DIGIT-1:0] an_d;
  logic               blank_d;

  onehot_index #(.IN_W(STATE_W)) u_index (
    .vec (state_vec),
    .idx (index_d)
  );

  digit_select #(.STATE_W(STATE_W)) u_select (
    .vec   (state_vec),
    .idx   (index_d),
    .sel   (scan_sel),
    .digit (digit_d)
  );

  anode_decode u_anode (
    .sel  (scan_sel),
    .an_n (an_d)
  );

  seg_decode u_seg (
    .hex   (digit_d),
    .seg_n (seg_d)
  );

  assign blank_d = state_vec[OPEN_BIT] & slow_clk;

  always_ff @(posedge clk) begin
    if (rst) begin
      an_n  <= '1;
      seg_n <= '1;
    end else begin
      an_n  <= an_d;
      seg_n <= seg_d | {SEG_W{blank_d}};
    end
  end
endmodule

// File: rtl/state_display_scan_chk.sv
module state_display_scan_chk #(
  parameter int STATE_W  = 11,
  parameter int OPEN_BIT = 9
) (
  input logic               clk,
  input logic               rst,
  input logic [1:0]         scan_sel,
  input logic               slow_clk,
  input logic [STATE_W-1:0] state_vec,
  input logic [3:0]         an_n,
  input logic [6:0]         seg_n
);
  logic started;
  logic rst_seen;

  always_ff @(posedge clk) begin
    if (rst) started <= 1'b0;
    else     started <= 1'b1;
    rst_seen <= rst;
  end

  always @(negedge clk) begin
    if (rst_seen === 1'b1)
      AST_RESET_DARK: assert (an_n == 4'hF && seg_n == 7'h7F); // R1
  end

  AST_ONE_ANODE: assert property (@(posedge clk) disable iff (rst)
    started |-> $countones(~an_n) == 1); // R2

  AST_ANODE_FOLLOWS_SEL: assert property (@(posedge clk) disable iff (rst)
    started |-> an_n[$past(scan_sel)] == 1'b0); // R9

  AST_BAD_INDEX_F: assert property (@(posedge clk) disable iff (rst)
    (started && $past(scan_sel) == 2'd0 && $past(state_vec) == '0)
      |-> seg_n == 7'b0001110); // R5

  AST_OPEN_BLANK: assert property (@(posedge clk) disable iff (rst)
    (started && $past(state_vec[OPEN_BIT]) && $past(slow_clk))
      |-> seg_n == 7'h7F); // R7

  AST_CLOSED_LIT: assert property (@(posedge clk) disable iff (rst)
    (started && !$past(state_vec[OPEN_BIT])) |-> seg_n != 7'h7F); // R8
endmodule

bind state_display_scan state_display_scan_chk #(
  .STATE_W  (STATE_W),
  .OPEN_BIT (OPEN_BIT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .scan_sel  (scan_sel),
  .slow_clk  (slow_clk),
  .state_vec (state_vec),
  .an_n      (an_n),
  .seg_n     (seg_n)
);

// File: tb/tb_state_display_scan.sv
module tb_state_display_scan;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  scan_sel = '0;
  logic        slow_clk = 1'b0;
  logic [10:0] state_vec = 11'h001;
  logic [3:0]  an_n;
  logic [6:0]  seg_n;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  // lit patterns, bit0=a .. bit6=g
  logic [6:0] lit_tab [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                               7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};

  always #2 clk = ~clk;

  state_display_scan dut (
    .clk(clk), .rst(rst), .scan_sel(scan_sel), .slow_clk(slow_clk),
    .state_vec(state_vec), .an_n(an_n), .seg_n(seg_n)
  );

  function automatic logic [3:0] model_index(logic [10:0] v);
    int n = 0;
    int p = 0;
    for (int i = 0; i < 11; i++) if (v[i]) begin n++; p = i; end
    return (n == 1) ? p[3:0] : 4'hF;
  endfunction

  function automatic logic [3:0] model_digit(logic [1:0] s, logic [10:0] v);
    logic [11:0] wide = {1'b0, v};
    if (s == 2'd0) return model_index(v);
    return 4'((wide >> (4 * (int'(s) - 1))) & 12'hF);
  endfunction

  task automatic apply(input logic r, input logic [1:0] s, input logic sl,
                       input logic [10:0] v, input string tag);
    logic [3:0] exp_an;
    logic [6:0] exp_seg;
    string      seg_tag;
    rst = r; scan_sel = s; slow_clk = sl; state_vec = v;
    if (r) begin
      exp_an = 4'hF; exp_seg = 7'h7F; seg_tag = "R1";
    end else begin
      exp_an = ~(4'b0001 << s);
      if (v[9] && sl) begin exp_seg = 7'h7F; seg_tag = "R7"; end
      else begin exp_seg = ~lit_tab[model_digit(s, v)]; seg_tag = tag; end
    end
    @(negedge clk);
    vectors++;
    if (an_n !== exp_an) begin
      fails++;
      $display("FAIL %s anodes: actual %b expected %b (sel=%0d)",
               r ? "R1" : (tag == "R9" ? "R9" : "R2"), an_n, exp_an, s);
    end
    if (seg_n !== exp_seg) begin
      fails++;
      $display("FAIL %s cathodes: actual %b expected %b (sel=%0d state=%h slow=%b)",
               seg_tag, seg_n, exp_seg, s, v, sl);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset darkens display regardless of inputs
    apply(1'b1, 2'd0, 1'b0, 11'h001, "R1");
    apply(1'b1, 2'd2, 1'b1, 11'h200, "R1");
    // R2 R3 R4: every valid state through every digit, slow low
    for (int st = 0; st < 11; st++)
      for (int k = 0; k < 4; k++)
        apply(1'b0, 2'(k), 1'b0, 11'(1 << st), (k == 0) ? "R4" : "R3");
    // R6: every hex glyph on the low raw digit
    for (int h = 0; h < 16; h++) apply(1'b0, 2'd1, 1'b0, 11'(h), "R6");
    // R5: empty and multi-bit vectors give F on the index digit
    apply(1'b0, 2'd0, 1'b0, 11'h000, "R5");
    apply(1'b0, 2'd0, 1'b0, 11'h003, "R5");
    apply(1'b0, 2'd0, 1'b0, 11'h7FF, "R5");
    apply(1'b0, 2'd0, 1'b0, 11'h600, "R5");
    // R7 R8: blink only for opening with slow high
    for (int k = 0; k < 4; k++) begin
      apply(1'b0, 2'(k), 1'b1, 11'h200, "R7");
      apply(1'b0, 2'(k), 1'b0, 11'h200, "R8");
      apply(1'b0, 2'(k), 1'b1, 11'h100, "R8");
      apply(1'b0, 2'(k), 1'b1, 11'h400, "R8");
      apply(1'b0, 2'(k), 1'b1, 11'h000, "R8");
    end
    // R9: select changes every cycle with shifting states
    for (int n = 0; n < 64; n++)
      apply(1'b0, 2'(n * 3), 1'(n / 5), 11'(1 << (n % 11)), "R9");
    // R1 again mid-run
    apply(1'b1, 2'd3, 1'b0, 11'h040, "R1");
    apply(1'b0, 2'd3, 1'b0, 11'h040, "R3");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule